// File: doc/BRIEF.md
# Masked Cascadable Bus Signature Compressor

This block watches a monitored data bus and, on every clock in which the test run is active, folds the current bus word into a signature register. The register is a multiple-input shift register with linear feedback. Any bus bit can be excluded through a per-bit mask, so a bit that is undefined or that toggles freely does not disturb the result. The same masked word can also be offered to an external capture memory through a write port. The port's address counter wraps at the end of the memory and records that the memory has been filled. A two-bit mode input chooses compression, capture or both.

Several units can be chained for a bus that is wider than one unit. A unit's role in the chain is fixed by a parameter. A low unit sends its top signature bit out on the chain output. A high unit uses the chain input as its feedback bit in place of its own top bit. A middle unit does both. A stand-alone unit neither drives nor uses the chain. A synchronous clear empties the signature, the address counter and the full flag.

Top module: `bus_sig_compressor`

## Requirements
- R1: After reset the signature is zero, the capture address is zero, the full flag is low and no capture write is offered.
- R2: On a clock with run high and mode bit 0 set, the signature becomes {sig[14:0],0} XOR (fb ? 16'h100B : 0) XOR (bus_data AND NOT bus_mask). The value 16'h100B is the polynomial x^16+x^12+x^3+x+1 without its top term. For a stand-alone or low unit, fb is sig[15].
- R3: A bus bit whose mask bit is 1 has no effect on the signature or on the captured word; in the captured word that bit position is 0.
- R4: While run is low, the signature and the capture address hold and cap_we is low, whatever the bus does.
- R5: Mode bit 0 enables compression and mode bit 1 enables capture, each independently of the other. With bit 0 clear the signature holds. With bit 1 clear no write is offered.
- R6: cap_we equals run AND mode bit 1, and cap_data is bus_data AND NOT bus_mask, in the same cycle. cap_addr is the current write address, and it advances by one after each write.
- R7: A write at address 1023 returns the address to 0 and sets cap_full. cap_full then stays high until a clear.
- R8: With clr high at a clock edge, the signature, the address and cap_full all become 0, even when run is high.
- R9: Low and middle units drive chain_out with their signature bit 15 and hold chain_oe at 1. High and stand-alone units hold chain_oe and chain_out at 0.
- R10: Middle and high units use chain_in as the feedback bit fb of R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Qualified sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of signature, address and full flag |
| run | input | 1 | Test operation active, from the event logic |
| mode | input | 2 | Bit 0 selects compression, bit 1 selects capture |
| bus_data | input | 16 | Monitored bus word |
| bus_mask | input | 16 | Per-bit mask, 1 excludes the bit |
| chain_in | input | 1 | Feedback bit from the lower unit of a chain |
| chain_out | output | 1 | Signature bit 15 offered to the upper unit |
| chain_oe | output | 1 | High when this unit drives the chain |
| signature | output | 16 | Parallel signature readback |
| cap_we | output | 1 | Capture memory write strobe |
| cap_addr | output | 10 | Capture memory write address |
| cap_data | output | 16 | Masked word to be written |
| cap_full | output | 1 | Capture memory has wrapped at least once |

## Verification
The assertions assume that clr, run, mode, bus_data and bus_mask are stable around each rising edge. They also assume that a chained unit's chain_in comes from a unit clocked by the same edge. The bench changes every input just after the falling edge. Its chained pair shares one clock, and the high unit's chain_in is wired to the low unit's chain_out. The stimulus sweeps the mask across every value its counter reaches. It flips masked bits against a replayed sequence, and it writes past the end of the memory, so the wrap and the sticky full flag are exercised.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
   typedef enum logic [1:0] {
      ROLE_SOLO = 2'd0,
      ROLE_LOW  = 2'd1,
      ROLE_MID  = 2'd2,
      ROLE_HIGH = 2'd3
   } chain_role_e;

   // bit 1: capture, bit 0: compress
   typedef struct packed {
      logic capture;
      logic compress;
   } run_mode_t;
endpackage

// File: rtl/bsc_mask.sv
module bsc_mask #(
   parameter int W = 16
) (
   input  logic [W-1:0] data,
   input  logic [W-1:0] mask,
   output logic [W-1:0] masked
);
   generate
      if (W < 1) begin : g_bad_w
         $error("bsc_mask: W must be positive");
      end
      for (genvar i = 0; i < W; i++) begin : g_bit
         assign masked[i] = data[i] & ~mask[i];
      end
   endgenerate
endmodule

// File: rtl/bsc_misr.sv
module bsc_misr #(
   parameter int                    W    = 16,
   parameter logic [W-1:0]          POLY = 16'h100B,
   parameter bsc_pkg::chain_role_e  ROLE = bsc_pkg::ROLE_SOLO
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         shift,
   input  logic [W-1:0] din,
   input  logic         chain_in,
   output logic [W-1:0] sig,
   output logic         chain_out,
   output logic         chain_oe
);
   import bsc_pkg::*;

   localparam bit TAKES_IN   = (ROLE == ROLE_MID) || (ROLE == ROLE_HIGH);
   localparam bit DRIVES_OUT = (ROLE == ROLE_MID) || (ROLE == ROLE_LOW);

   generate
      if (W < 2) begin : g_bad_w
         $error("bsc_misr: W must be at least 2");
      end
      if (POLY[0] != 1'b1) begin : g_bad_poly
         $error("bsc_misr: polynomial must include the constant term");
      end
   endgenerate

   logic [W-1:0] sig_q;
   logic [W-1:0] sig_d;
   logic         fb;

   assign fb    = TAKES_IN ? chain_in : sig_q[W-1];
   assign sig_d = {sig_q[W-2:0], 1'b0} ^ ({W{fb}} & POLY) ^ din;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sig_q <= '0;
      else if (clr)    sig_q <= '0;
      else if (shift)  sig_q <= sig_d;
   end

   assign sig = sig_q;

   generate
      if (DRIVES_OUT) begin : g_drive
         assign chain_out = sig_q[W-1];
         assign chain_oe  = 1'b1;
      end else begin : g_quiet
         assign chain_out = 1'b0;
         assign chain_oe  = 1'b0;
      end
   endgenerate

   a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !shift) |=> $stable(sig_q));

   a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (sig_q == '0));
endmodule

// File: rtl/bsc_capture.sv
module bsc_capture #(
   parameter int W     = 16,
   parameter int DEPTH = 1024
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clr,
   input  logic                     wr,
   input  logic [W-1:0]             din,
   output logic                     we,
   output logic [$clog2(DEPTH)-1:0] addr,
   output logic [W-1:0]             wdata,
   output logic                     full
);
   localparam int            AW   = $clog2(DEPTH);
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("bsc_capture: DEPTH must be at least 2");
      end
   endgenerate

   logic [AW-1:0] addr_q;
   logic          full_q;
   logic          at_last;

   assign at_last = (addr_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         full_q <= 1'b0;
      end else if (clr) begin
         addr_q <= '0;
         full_q <= 1'b0;
      end else if (wr) begin
         if (at_last) begin
            addr_q <= '0;
            full_q <= 1'b1;
         end else begin
            addr_q <= addr_q + 1'b1;
         end
      end
   end

   assign we    = wr;
   assign addr  = addr_q;
   assign wdata = din;
   assign full  = full_q;

   a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !clr && !at_last) |=> (addr_q == $past(addr_q) + 1'b1));

   a_r7_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !clr && at_last) |=> (full_q && addr_q == '0));

   a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (full_q && !clr) |=> full_q);

   a_r4_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr && !clr) |=> $stable(addr_q));
endmodule

// File: rtl/bus_sig_compressor.sv
module bus_sig_compressor #(
   parameter int                   W     = 16,
   parameter int                   DEPTH = 1024,
   parameter logic [W-1:0]         POLY  = 16'h100B,
   parameter bsc_pkg::chain_role_e ROLE  = bsc_pkg::ROLE_SOLO
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clr,
   input  logic                     run,
   input  logic [1:0]               mode,
   input  logic [W-1:0]             bus_data,
   input  logic [W-1:0]             bus_mask,
   input  logic                     chain_in,
   output logic                     chain_out,
   output logic                     chain_oe,
   output logic [W-1:0]             signature,
   output logic                     cap_we,
   output logic [$clog2(DEPTH)-1:0] cap_addr,
   output logic [W-1:0]             cap_data,
   output logic                     cap_full
);
   import bsc_pkg::*;

   run_mode_t    mode_s;
   logic [W-1:0] masked;
   logic         do_shift;
   logic         do_write;

   assign mode_s   = run_mode_t'(mode);
   assign do_shift = run & mode_s.compress;
   assign do_write = run & mode_s.capture;

   bsc_mask #(.W(W)) u_mask (
      .data   (bus_data),
      .mask   (bus_mask),
      .masked (masked)
   );

   bsc_misr #(.W(W), .POLY(POLY), .ROLE(ROLE)) u_misr (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr),
      .shift     (do_shift),
      .din       (masked),
      .chain_in  (chain_in),
      .sig       (signature),
      .chain_out (chain_out),
      .chain_oe  (chain_oe)
   );

   bsc_capture #(.W(W), .DEPTH(DEPTH)) u_cap (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .wr    (do_write),
      .din   (masked),
      .we    (cap_we),
      .addr  (cap_addr),
      .wdata (cap_data),
      .full  (cap_full)
   );

   a_r3_mask_out: assert property (@(posedge clk) disable iff (!rst_n)
      cap_we |-> ((cap_data & bus_mask) == '0));

   a_r4_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> !cap_we);
endmodule

// File: tb/bus_sig_compressor_tb.sv
module bus_sig_compressor_tb;
   import bsc_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam logic [15:0] POLY = 16'h100B;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   // stand-alone unit
   logic        clr = 0, run = 0;
   logic [1:0]  mode = 0;
   logic [15:0] data = 0, mask = 0;
   logic        c_out, c_oe, we, full;
   logic [15:0] sig, wdata;
   logic [9:0]  addr;

   bus_sig_compressor u_dut (
      .clk(clk), .rst_n(rst_n), .clr(clr), .run(run), .mode(mode),
      .bus_data(data), .bus_mask(mask), .chain_in(1'b0),
      .chain_out(c_out), .chain_oe(c_oe), .signature(sig),
      .cap_we(we), .cap_addr(addr), .cap_data(wdata), .cap_full(full));

   // chained pair
   logic        k_clr = 0, k_run = 0;
   logic [15:0] d_lo = 0, d_hi = 0;
   logic        lo_out, lo_oe, hi_out, hi_oe;
   logic [15:0] s_lo, s_hi;
   logic        lo_we, hi_we, lo_full, hi_full;
   logic [9:0]  lo_addr, hi_addr;
   logic [15:0] lo_wd, hi_wd;

   bus_sig_compressor #(.ROLE(ROLE_LOW)) u_lo (
      .clk(clk), .rst_n(rst_n), .clr(k_clr), .run(k_run), .mode(2'b01),
      .bus_data(d_lo), .bus_mask(16'h0000), .chain_in(1'b0),
      .chain_out(lo_out), .chain_oe(lo_oe), .signature(s_lo),
      .cap_we(lo_we), .cap_addr(lo_addr), .cap_data(lo_wd), .cap_full(lo_full));

   bus_sig_compressor #(.ROLE(ROLE_HIGH)) u_hi (
      .clk(clk), .rst_n(rst_n), .clr(k_clr), .run(k_run), .mode(2'b01),
      .bus_data(d_hi), .bus_mask(16'h0000), .chain_in(lo_out),
      .chain_out(hi_out), .chain_oe(hi_oe), .signature(s_hi),
      .cap_we(hi_we), .cap_addr(hi_addr), .cap_data(hi_wd), .cap_full(hi_full));

   int checks = 0, errors = 0;
   logic [15:0] rng = 16'hACE1;
   logic [15:0] ref_sig, ref_lo, ref_hi;
   int          ref_addr;
   logic        ref_full;
   logic [15:0] mem_ref [1024];
   logic [15:0] mem_dut [1024];

   always @(posedge clk) if (we) mem_dut[addr] <= wdata;

   function automatic logic [15:0] nsig(logic [15:0] s, logic fb, logic [15:0] d);
      return {s[14:0], 1'b0} ^ (fb ? POLY : 16'h0) ^ d;
   endfunction

   function automatic logic [15:0] xs(logic [15:0] v);
      logic [15:0] t = v;
      t = t ^ (t << 7);
      t = t ^ (t >> 9);
      t = t ^ (t << 8);
      return (t == 0) ? 16'h1 : t;
   endfunction

   task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   // one solo-unit cycle: inputs already set; check comb outputs, advance model
   task automatic solo_cycle(input string tag);
      logic        ew;
      logic [15:0] md;
      #1;
      ew = run & mode[1];
      md = data & ~mask;
      check(we == ew, {tag, " R6 we"}, 32'(we), 32'(ew));
      if (ew) begin
         check(addr == 10'(ref_addr), {tag, " R6 addr"}, 32'(addr), 32'(ref_addr));
         check(wdata == md, {tag, " R3 wdata"}, 32'(wdata), 32'(md));
      end
      if (clr) begin
         ref_sig = 0; ref_addr = 0; ref_full = 0;
      end else begin
         if (run & mode[0]) ref_sig = nsig(ref_sig, ref_sig[15], md);
         if (ew) begin
            mem_ref[ref_addr] = md;
            if (ref_addr == 1023) begin ref_addr = 0; ref_full = 1; end
            else ref_addr++;
         end
      end
      tick();
      check(sig == ref_sig, {tag, " R2 signature"}, 32'(sig), 32'(ref_sig));
      check(full == ref_full, {tag, " R7 full"}, 32'(full), 32'(ref_full));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [15:0] seed, first;
      int fails;
      ref_sig = 0; ref_addr = 0; ref_full = 0;
      for (int i = 0; i < 1024; i++) begin mem_ref[i] = 0; mem_dut[i] = 0; end
      repeat (3) @(negedge clk);
      // R1 reset state
      check(sig == 0, "R1 sig", 32'(sig), 0);
      check(addr == 0, "R1 addr", 32'(addr), 0);
      check(full == 0, "R1 full", 32'(full), 0);
      check(we == 0, "R1 we", 32'(we), 0);
      rst_n = 1;
      @(negedge clk);
      // R9 roles
      check(c_oe == 0 && c_out == 0, "R9 solo quiet", {30'b0, c_oe, c_out}, 0);
      check(lo_oe == 1, "R9 low oe", 32'(lo_oe), 1);
      check(hi_oe == 0 && hi_out == 0, "R9 high quiet", {30'b0, hi_oe, hi_out}, 0);

      // R2/R5: compression only, mask zero, varied data
      run = 1; mode = 2'b01;
      for (int i = 0; i < 300; i++) begin
         rng = xs(rng); data = rng; solo_cycle("R2 compress");
      end
      // R4: run low, data keeps moving
      run = 0;
      for (int i = 0; i < 8; i++) begin
         rng = xs(rng); data = rng; solo_cycle("R4 idle");
      end
      // R5: run high, both mode bits clear
      run = 1; mode = 2'b00;
      for (int i = 0; i < 8; i++) begin
         rng = xs(rng); data = rng; solo_cycle("R5 off");
      end
      // R3: replay with masked bits flipped, compare signatures
      mode = 2'b01; mask = 16'hF0F0; clr = 1; solo_cycle("R8 clr");
      clr = 0; seed = 16'h1234;
      for (int i = 0; i < 64; i++) begin seed = xs(seed); data = seed; solo_cycle("R3 pass1"); end
      first = sig;
      clr = 1; solo_cycle("R8 clr2"); clr = 0; seed = 16'h1234;
      for (int i = 0; i < 64; i++) begin
         seed = xs(seed); rng = xs(rng); data = seed ^ (rng & mask); solo_cycle("R3 pass2");
      end
      check(sig == first, "R3 masked bits ignored", 32'(sig), 32'(first));
      // R3 mask sweep during compression
      mask = 0;
      for (int i = 0; i < 200; i++) begin
         rng = xs(rng); data = rng; mask = 16'(i * 16'h0101); solo_cycle("R3 sweep");
      end
      // R8: clear while running
      clr = 1; run = 1; solo_cycle("R8 run clr");
      check(sig == 0 && addr == 0, "R8 cleared", {sig, 6'b0, addr}, 0);
      clr = 0;
      // R6/R7: capture only, past the end of memory, mask sweep
      mode = 2'b10;
      for (int i = 0; i < 1030; i++) begin
         rng = xs(rng); data = rng; mask = 16'(i); solo_cycle("R7 capture");
         if (i == 1022) check(full == 0, "R7 not yet full", 32'(full), 0);
         if (i == 1023) check(addr == 0 && full == 1, "R7 wrap", {full, 21'b0, addr}, 32'h8000_0000);
      end
      check(addr == 10'd6, "R7 addr after wrap", 32'(addr), 6);
      fails = 0;
      for (int i = 0; i < 1024; i++) if (mem_dut[i] !== mem_ref[i]) fails++;
      check(fails == 0, "R6 memory contents", 32'(fails), 0);
      // R5: both modes, then R4 with run low and full sticky
      mode = 2'b11; mask = 16'h00FF;
      for (int i = 0; i < 40; i++) begin rng = xs(rng); data = rng; solo_cycle("R5 both"); end
      run = 0;
      for (int i = 0; i < 5; i++) begin rng = xs(rng); data = rng; solo_cycle("R4 hold"); end
      check(full == 1, "R7 sticky", 32'(full), 1);
      clr = 1; solo_cycle("R8 full clr"); clr = 0;
      check(full == 0, "R8 full cleared", 32'(full), 0);

      // R9/R10: chained pair
      ref_lo = 0; ref_hi = 0; k_run = 1;
      for (int i = 0; i < 250; i++) begin
         logic [15:0] plo;
         rng = xs(rng); d_lo = rng; rng = xs(rng); d_hi = rng;
         #1;
         check(lo_out == s_lo[15], "R9 chain out", 32'(lo_out), 32'(s_lo[15]));
         plo = ref_lo;
         ref_lo = nsig(ref_lo, ref_lo[15], d_lo);
         ref_hi = nsig(ref_hi, plo[15], d_hi);
         tick();
         check(s_lo == ref_lo, "R2 low unit", 32'(s_lo), 32'(ref_lo));
         check(s_hi == ref_hi, "R10 high unit", 32'(s_hi), 32'(ref_hi));
      end
      k_run = 0;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule